// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial protocol engine of a 256-byte nonvolatile array that is organised as 16 pages of 16 bytes. When the engine has received the word address of a write transaction, it pulses `txn_begin`. Each data byte the engine accepts arrives on `byte_stb`. The block places every byte into a 16-entry page buffer. Each entry has its own valid flag, and the slot is chosen by the low four bits of an address pointer. That pointer wraps inside the current page.

When the transaction closes with a Stop, the block launches one self-timed write cycle, but only if at least one byte was collected and hardware write protection is low. During that cycle `busy` is held for a programmable number of system clocks. The protocol engine uses `busy` to withhold its address acknowledge, so a master can poll for completion. In the first sixteen clocks of the cycle, the block presents the valid buffer entries on a simple array write port, in ascending slot order. The physical cell programming behind that port is not part of this block.

The pointer remains visible on `cur_ptr`, so the engine can serve current-address reads from it.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and `cur_ptr` is 0x00.
- R2: A `txn_begin` pulse accepted while not busy loads `cur_ptr` from `txn_addr`, clears all buffer valid flags and opens a transaction.
- R3: Each `byte_stb` in an open transaction stores `byte_in` in the slot given by `cur_ptr[3:0]` and increments only `cur_ptr[3:0]`, wrapping from 15 to 0. `cur_ptr[7:4]` does not change.
- R4: When more than 16 bytes arrive in one transaction, the byte received last for a slot is the one committed to that slot.
- R5: A commit starts only on `stop_evt` in an open transaction that holds at least one byte. A transaction closed by `start_evt`, or one that holds no byte, leaves `busy` low and produces no array write.
- R6: `busy` rises in the clock after the accepted Stop and stays high for exactly WR_CYCLES clocks.
- R7: During a commit, exactly one `mem_we` pulse is issued per valid slot, in ascending slot order within the first 16 busy clocks. The address of each pulse is {`cur_ptr[7:4]`, slot}. Slots without a byte in this transaction receive no write.
- R8: If `wp` is high at the Stop, no array write occurs and `busy` stays low. The bytes are still taken, and the pointer still advances.
- R9: While `busy` is high, `txn_begin`, `byte_stb`, `stop_evt` and `start_evt` have no effect on the pointer, the buffer or the commit.
- R10: After a commit, `cur_ptr` equals the address after the last byte received, wrapped inside its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin | input | 1 | Word address of a write transaction received |
| txn_addr | input | 8 | Word address carried with `txn_begin` |
| byte_stb | input | 1 | One data byte accepted by the protocol engine |
| byte_in | input | 8 | Data byte carried with `byte_stb` |
| stop_evt | input | 1 | Stop condition seen on the bus |
| start_evt | input | 1 | Start or repeated Start seen on the bus |
| wp | input | 1 | Hardware write protect, active high |
| busy | output | 1 | Write cycle in progress; address must not be acknowledged |
| cur_ptr | output | 8 | Current address pointer |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench targets transactions that start near the end of a page. A design that carries into the page bits would commit bytes to the next page, and would leave `cur_ptr` in the wrong page. A 20-byte transaction checks that the late bytes replace the early ones. A design that kept the first copy, or wrote a slot twice, would show the wrong data or an extra write.

Transactions closed by a Start, transactions with no data, and transactions under write protection must all leave `busy` low and produce no write. A design that commits on any bus event would raise `busy` on each of them.

A second transaction is driven while a commit is running. A design that does not block its inputs while busy would move the pointer or start a second commit.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_OPEN = 1'b1
  } tx_state_e;

endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic              busy,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [PAGE_W-1:0] slot_inc;

  assign slot_inc = ptr_q[PAGE_W-1:0] + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (load) begin
      ptr_d = load_addr;
    end else if (adv) begin
      ptr_d = {ptr_q[ADDR_W-1:PAGE_W], slot_inc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load || adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R3

  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ptr)); // R9

endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  valid_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    logic valid_d;

    assign hit = wr_en && (wr_slot == PAGE_W'(s));

    always_comb begin
      valid_d = valid_q[s];
      if (clr) begin
        valid_d = 1'b0;
      end else if (hit) begin
        valid_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (clr || hit) begin
        valid_q[s] <= valid_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[s] <= '0;
      end else if (hit) begin
        data_q[s] <= wr_data;
      end
    end
  end

  assign rd_data   = data_q[rd_slot];
  assign rd_valid  = valid_q[rd_slot];
  assign any_valid = |valid_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_valid); // R2

endmodule

// File: rtl/pcb_commit_timer.sv
module pcb_commit_timer #(
  parameter int WR_CYCLES = 200,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q || go) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R6

  AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == LAST)); // R6

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_begin,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_evt,
  input  logic              start_evt,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  import pcb_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES) + 1;
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  tx_state_e tx_q, tx_d;

  logic              begin_ok, byte_ok, stop_ok, start_ok;
  logic              go;
  logic [CNT_W-1:0]  tcnt;
  logic [PAGE_W-1:0] scan_slot;
  logic              scan_phase;
  logic [DATA_W-1:0] slot_data;
  logic              slot_valid;
  logic              any_valid;

  // Accepted events: all inputs are ignored while a commit runs.
  assign begin_ok = txn_begin && !busy;
  assign byte_ok  = byte_stb  && !busy && (tx_q == TX_OPEN) && !txn_begin;
  assign stop_ok  = stop_evt  && !busy && (tx_q == TX_OPEN) && !txn_begin;
  assign start_ok = start_evt && !busy && (tx_q == TX_OPEN) && !txn_begin;

  always_comb begin
    tx_d = tx_q;
    if (begin_ok) begin
      tx_d = TX_OPEN;
    end else if (stop_ok || start_ok) begin
      tx_d = TX_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= TX_IDLE;
    end else if (begin_ok || stop_ok || start_ok) begin
      tx_q <= tx_d;
    end
  end

  // A byte on the same clock as the Stop is taken first but cannot count yet.
  assign go = stop_ok && any_valid && !wp;

  pcb_addr_ctr #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (begin_ok),
    .load_addr (txn_addr),
    .adv       (byte_ok),
    .busy      (busy),
    .ptr       (cur_ptr)
  );

  pcb_page_buf #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (begin_ok),
    .wr_en     (byte_ok),
    .wr_slot   (cur_ptr[PAGE_W-1:0]),
    .wr_data   (byte_in),
    .rd_slot   (scan_slot),
    .rd_data   (slot_data),
    .rd_valid  (slot_valid),
    .any_valid (any_valid)
  );

  pcb_commit_timer #(
    .WR_CYCLES (WR_CYCLES),
    .CNT_W     (CNT_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .busy  (busy),
    .cnt   (tcnt)
  );

  assign scan_slot  = tcnt[PAGE_W-1:0];
  assign scan_phase = busy && (tcnt < SCAN_END);
  assign mem_we     = scan_phase && slot_valid;
  assign mem_addr   = {cur_ptr[ADDR_W-1:PAGE_W], scan_slot};
  assign mem_wdata  = slot_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R7

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt)); // R5

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp)); // R8

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (tx_q == TX_IDLE)); // R9

endmodule

// File: tb/page_commit_buffer_test.sv
module page_commit_buffer_test;

  localparam int CLK_P = 10;
  localparam int WR    = 200;
  localparam int NV    = 8;

  // Vector columns: start address, byte count, data seed, wp, closed by Stop (1) or Start (0)
  localparam int V_ADDR [NV] = '{8'h00, 8'h35, 8'h7C, 8'hA0, 8'h40, 8'h20, 8'h90, 8'hFF};
  localparam int V_CNT  [NV] = '{1, 4, 6, 20, 3, 5, 0, 16};
  localparam int V_SEED [NV] = '{8'h5A, 8'h11, 8'hC3, 8'h20, 8'h77, 8'h99, 8'h01, 8'hE0};
  localparam int V_WP   [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_STOP [NV] = '{1, 1, 1, 1, 1, 0, 1, 1};

  logic       clk, rst_n;
  logic       txn_begin, byte_stb, stop_evt, start_evt, wp;
  logic [7:0] txn_addr, byte_in;
  logic       busy, mem_we;
  logic [7:0] cur_ptr, mem_addr, mem_wdata;

  int total, bad;
  logic       got_v [256];
  logic [7:0] got_d [256];
  int got_cnt, dup_cnt, busy_cnt, order_bad, last_addr;

  page_commit_buffer #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .txn_begin(txn_begin), .txn_addr(txn_addr),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop_evt(stop_evt),
    .start_evt(start_evt), .wp(wp), .busy(busy), .cur_ptr(cur_ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
        if (got_v[mem_addr]) dup_cnt++;
        if (int'(mem_addr) <= last_addr) order_bad++;
        last_addr = int'(mem_addr);
        got_v[mem_addr] = 1'b1;
        got_d[mem_addr] = mem_wdata;
        got_cnt++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 256; i++) begin
      got_v[i] = 1'b0;
      got_d[i] = 8'h00;
    end
    got_cnt = 0; dup_cnt = 0; busy_cnt = 0; order_bad = 0; last_addr = -1;
  endtask

  task automatic send_begin(input logic [7:0] a);
    @(negedge clk); txn_begin = 1'b1; txn_addr = a;
    @(negedge clk); txn_begin = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1'b1; byte_in = d;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic send_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic run_vec(input int k);
    logic [7:0] exp_d [16];
    logic       exp_v [16];
    logic [7:0] a, page, pexp;
    int  commits, nexp;
    a = 8'(V_ADDR[k]);
    page = a & 8'hF0;
    for (int s = 0; s < 16; s++) begin exp_v[s] = 1'b0; exp_d[s] = 8'h00; end
    for (int i = 0; i < V_CNT[k]; i++) begin
      exp_v[(a + i) & 15] = 1'b1;
      exp_d[(a + i) & 15] = 8'(V_SEED[k] + 7 * i);
    end
    commits = (V_STOP[k] == 1 && V_WP[k] == 0 && V_CNT[k] > 0) ? 1 : 0;
    nexp = 0;
    for (int s = 0; s < 16; s++) if (exp_v[s]) nexp++;
    if (commits == 0) nexp = 0;
    pexp = page | 8'((a + V_CNT[k]) & 15);
    clear_log();
    wp = V_WP[k][0];
    send_begin(a);
    check("R2 pointer load", int'(cur_ptr), int'(a));
    for (int i = 0; i < V_CNT[k]; i++) send_byte(8'(V_SEED[k] + 7 * i));
    if (V_STOP[k] == 1) send_stop(); else send_start();
    repeat (WR + 5) @(negedge clk);
    wp = 1'b0;
    check("R5 R8 write count", got_cnt, nexp);
    check("R6 busy length", busy_cnt, commits * WR);
    check("R7 no repeated slot", dup_cnt, 0);
    check("R7 ascending order", order_bad, 0);
    check("R10 pointer after txn", int'(cur_ptr), int'(pexp));
    if (commits == 1) begin
      for (int s = 0; s < 16; s++) begin
        check("R7 slot written iff valid", int'(got_v[page | 8'(s)]), int'(exp_v[s]));
        if (exp_v[s]) check("R3 R4 slot data", int'(got_d[page | 8'(s)]), int'(exp_d[s]));
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    txn_begin = 1'b0; byte_stb = 1'b0; stop_evt = 1'b0; start_evt = 1'b0; wp = 1'b0;
    txn_addr = 8'h00; byte_in = 8'h00;
    clear_log();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 mem_we at reset", int'(mem_we), 0);
    check("R1 pointer at reset", int'(cur_ptr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R6: busy rises in the clock right after the Stop
    clear_log();
    send_begin(8'h10);
    send_byte(8'hAB);
    send_byte(8'hCD);
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    check("R6 busy one clock after stop", int'(busy), 1);
    // R9: traffic during the commit has no effect
    send_begin(8'h55);
    send_byte(8'h01);
    send_byte(8'h02);
    send_stop();
    check("R9 pointer held while busy", int'(cur_ptr), 8'h12);
    repeat (WR + 5) @(negedge clk);
    check("R9 only first commit written", got_cnt, 2);
    check("R9 single busy window", busy_cnt, WR);
    check("R9 no write to ignored address", int'(got_v[8'h55]), 0);
    check("R10 pointer after commit", int'(cur_ptr), 8'h12);
    check("R7 data slot 0", int'(got_d[8'h10]), 8'hAB);
    check("R7 data slot 1", int'(got_d[8'h11]), 8'hCD);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule